// File: doc/BRIEF.md
# Shadow-Memory Store/Recall Controller

This block owns a small working SRAM array, modelled as registers, together with a shadow copy that stands in for nonvolatile storage. It copies the whole working array into the shadow in one operation (STORE) and copies the shadow back into the working array (RECALL). A RECALL runs by itself after every reset, so the working array comes up holding what was last stored.

A STORE has three possible triggers. The first is a falling edge on an active-low hardware request line. The second is a one-cycle software request pulse. The third is a rising edge on a power-fail comparator input. Hardware and power-fail requests are dropped when nothing has been written since the last transfer. Software requests always run. While any transfer is running, the busy output is low, the access gate blocks every read and write on the SRAM-style bus (chip enable, output enable, write enable), and new triggers are discarded. A saturating counter records how many stores have run, to help track wear.

Top module: `shadow_store_ctrl`

## Requirements
- R1: The read drivers are on (`rdata_oe`=1, `rdata` = the addressed word) only while `ce_n`=0, `oe_n`=0, `we_n`=1, `hw_req_n`=1 and no transfer is running. In every other case `rdata_oe`=0 and `rdata`=0.
- R2: A write is accepted while `ce_n`=0, `we_n`=0, `hw_req_n`=1 and the block is idle. The word is committed on the first clock edge at which `ce_n` or `we_n` is high again. It uses the address and data sampled at the last edge where the write condition held.
- R3: With `oe_n` low and `we_n` low together, the read drivers stay off.
- R4: While a transfer runs, reads return `rdata_oe`=0 and attempted writes leave the array unchanged.
- R5: Reset holds `busy_n` low and `store_count` at 0. After reset is released, a RECALL keeps `busy_n` low for RECALL_CYC cycles in total and then restores the last stored contents.
- R6: A STORE keeps `busy_n` low for STORE_CYC cycles. When it completes, the shadow holds the array as it was during the store.
- R7: A software request (`sw_store`=1 for one cycle) starts a store even when no write has happened.
- R8: A hardware request (falling edge of `hw_req_n`) or a power-fail request (rising edge of `pwr_fail`) is skipped when no write has happened since the last transfer. When skipped, `busy_n` stays high and the count is unchanged.
- R9: Any accepted write marks the array dirty. Completion of any STORE or RECALL clears the dirty mark.
- R10: When requests arrive in the same cycle, the priority is power-fail, then hardware, then software. A skipped clean request does not block a lower-priority one. While busy, `store_src` reports the winner: 3 for power-fail, 2 for hardware, 1 for software, 0 otherwise.
- R11: Any request that arrives while a transfer is running is discarded.
- R12: `store_count` goes up by one for each store that runs. It never goes up for a skipped store, and it stops at 2^CNT_W-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Word address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, zero when drivers off |
| rdata_oe | output | 1 | Read driver enable |
| hw_req_n | input | 1 | Hardware store request line, active low, idles high |
| sw_store | input | 1 | Software store request pulse |
| pwr_fail | input | 1 | Power-fail comparator output, high on failure |
| busy_n | output | 1 | Low while a STORE or RECALL runs |
| store_src | output | 2 | Source of the running store |
| store_count | output | CNT_W | Saturating count of executed stores |

## Verification
Trigger arbitration and the dirty check meet in the same cycle. A table drives power-fail, hardware and software requests together or alone, both after a write and with a clean array. The bench judges the result by the immediate state of `busy_n`, by the reported `store_src`, and by the change in `store_count`. Separately, a power-fail edge and a write attempt are landed inside a running store. The bench then checks that the count rises only once and that the array word is unchanged.

// File: rtl/sstore_pkg.sv
// Shared types for the shadow store/recall controller.
// Assumes: encodings below are visible at the top-level store_src port.
package sstore_pkg;
    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_SW   = 2'd1,
        SRC_HW   = 2'd2,
        SRC_PF   = 2'd3
    } src_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_STORE  = 2'd1,
        ST_RECALL = 2'd2
    } state_e;
endpackage

// File: rtl/sstore_trig_arb.sv
// Trigger arbiter: detects request edges and picks one store source.
// Assumes: requests are synchronous to clk; the dirty flag is registered
// elsewhere; requests outside idle are dropped, not queued.
module sstore_trig_arb
    import sstore_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic idle,
    input  logic dirty,
    input  logic pwr_fail,
    input  logic hw_req_n,
    input  logic sw_store,
    output src_e start_src
);
    logic pf_q;
    logic hw_q;
    logic pf_edge;
    logic hw_edge;

    // Previous values of the edge-triggered request inputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pf_q <= 1'b0;
            hw_q <= 1'b1;
        end else begin
            pf_q <= pwr_fail;
            hw_q <= hw_req_n;
        end
    end

    assign pf_edge = pwr_fail && !pf_q;
    assign hw_edge = !hw_req_n && hw_q;

    // Fixed-priority pick; clean hardware/power-fail requests count as absent.
    always_comb begin
        start_src = SRC_NONE;
        if (idle) begin
            if (pf_edge && dirty)      start_src = SRC_PF;
            else if (hw_edge && dirty) start_src = SRC_HW;
            else if (sw_store)         start_src = SRC_SW;
        end
    end
endmodule

// File: rtl/sstore_seq.sv
// Transfer sequencer: runs STORE and RECALL for fixed cycle counts.
// Assumes: STORE_CYC and RECALL_CYC are at least 1; a RECALL follows reset.
module sstore_seq
    import sstore_pkg::*;
#(
    parameter int STORE_CYC  = 8,
    parameter int RECALL_CYC = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  src_e start_src,
    output logic idle,
    output logic store_done,
    output logic recall_done,
    output src_e cur_src
);
    localparam int MAXC = (STORE_CYC > RECALL_CYC) ? STORE_CYC : RECALL_CYC;
    localparam int CW   = (MAXC > 1) ? $clog2(MAXC) : 1;
    localparam logic [CW-1:0] LAST_S = CW'(STORE_CYC - 1);
    localparam logic [CW-1:0] LAST_R = CW'(RECALL_CYC - 1);

    state_e         st_q;
    logic [CW-1:0]  cnt_q;
    src_e           src_q;
    logic           last;

    assign last = (st_q == ST_STORE)  ? (cnt_q == LAST_S) :
                  (st_q == ST_RECALL) ? (cnt_q == LAST_R) : 1'b0;

    // State, cycle count and captured source of the running transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_RECALL;
            cnt_q <= '0;
            src_q <= SRC_NONE;
        end else if (st_q == ST_IDLE) begin
            if (start_src != SRC_NONE) begin
                st_q  <= ST_STORE;
                cnt_q <= '0;
                src_q <= start_src;
            end
        end else if (last) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
            src_q <= SRC_NONE;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign idle        = (st_q == ST_IDLE);
    assign store_done  = (st_q == ST_STORE) && last;
    assign recall_done = (st_q == ST_RECALL) && last;
    assign cur_src     = src_q;

    // R6
    store_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_STORE) |-> (cnt_q <= LAST_S));

    // R11
    busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_src != SRC_NONE) |-> (st_q == ST_IDLE));

    // R5
    recall_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE) |=> (st_q != ST_RECALL));
endmodule

// File: rtl/sstore_array.sv
// Working array, shadow copy and bus access gate.
// Assumes: array and shadow are not reset (shadow models nonvolatile
// contents); bus inputs are synchronous to clk.
module sstore_array #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic              hw_req_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              idle,
    input  logic              store_done,
    input  logic              recall_done,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_oe,
    output logic              dirty
);
    localparam int DEPTH = 1 << ADDR_W;

    logic              wr_cond;
    logic              rd_cond;
    logic              commit;
    logic              wr_act_q;
    logic [ADDR_W-1:0] lat_addr;
    logic [DATA_W-1:0] lat_data;
    logic              dirty_q;
    logic [DATA_W-1:0] word_rd [DEPTH];

    assign wr_cond = !ce_n && !we_n && hw_req_n && idle;
    assign rd_cond = !ce_n && !oe_n && we_n && hw_req_n && idle;
    assign commit  = wr_act_q && idle && hw_req_n && (ce_n || we_n);

    // Tracks an open write and samples its address and data each cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_act_q <= 1'b0;
            lat_addr <= '0;
            lat_data <= '0;
        end else begin
            wr_act_q <= wr_cond;
            if (wr_cond) begin
                lat_addr <= addr;
                lat_data <= wdata;
            end
        end
    end

    // Dirty mark: set by a committed write, cleared by a finished transfer.
    always_ff @(posedge clk) begin
        if (!rst_n)                        dirty_q <= 1'b0;
        else if (store_done || recall_done) dirty_q <= 1'b0;
        else if (commit)                   dirty_q <= 1'b1;
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_word
        logic [DATA_W-1:0] work_q;
        logic [DATA_W-1:0] shad_q;

        // Working word: restored by RECALL or updated by a committed write.
        always_ff @(posedge clk) begin
            if (recall_done)                                work_q <= shad_q;
            else if (commit && (lat_addr == ADDR_W'(g)))    work_q <= lat_data;
        end

        // Shadow word: captured from the working word when STORE ends.
        always_ff @(posedge clk) begin
            if (store_done) shad_q <= work_q;
        end

        assign word_rd[g] = work_q;
    end

    assign rdata    = rd_cond ? word_rd[addr] : '0;
    assign rdata_oe = rd_cond;
    assign dirty    = dirty_q;

    // R9
    dirty_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> dirty_q);

    // R9
    dirty_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (store_done || recall_done) |=> !dirty_q);

    // R4
    no_open_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !idle |=> !wr_act_q);
endmodule

// File: rtl/sstore_counter.sv
// Saturating counter of executed stores.
// Assumes: inc is a single-cycle pulse per completed store.
module sstore_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;
    logic             past_ok;

    // Count executed stores, holding at the top value.
    always_ff @(posedge clk) begin
        if (!rst_n)                    cnt_q <= '0;
        else if (inc && cnt_q != CMAX) cnt_q <= cnt_q + 1'b1;
    end

    // Marks that one clock has passed since reset, for history checks.
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    assign cnt = cnt_q;

    // R12
    cnt_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> (cnt_q >= $past(cnt_q)));

    // R12
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !$past(inc)) |-> $stable(cnt_q));
endmodule

// File: rtl/shadow_store_ctrl.sv
// Top: shadow-memory store/recall controller.
// Assumes: all inputs synchronous to clk; busy_n and hw_req_n are kept as
// separate pins (an external open-drain merge is left to the pad ring).
module shadow_store_ctrl
    import sstore_pkg::*;
#(
    parameter int ADDR_W     = 4,
    parameter int DATA_W     = 8,
    parameter int STORE_CYC  = 8,
    parameter int RECALL_CYC = 6,
    parameter int CNT_W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_oe,
    input  logic              hw_req_n,
    input  logic              sw_store,
    input  logic              pwr_fail,
    output logic              busy_n,
    output logic [1:0]        store_src,
    output logic [CNT_W-1:0]  store_count
);
    logic idle;
    logic dirty;
    logic store_done;
    logic recall_done;
    src_e start_src;
    src_e cur_src;

    sstore_trig_arb u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .idle      (idle),
        .dirty     (dirty),
        .pwr_fail  (pwr_fail),
        .hw_req_n  (hw_req_n),
        .sw_store  (sw_store),
        .start_src (start_src)
    );

    sstore_seq #(
        .STORE_CYC  (STORE_CYC),
        .RECALL_CYC (RECALL_CYC)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_src   (start_src),
        .idle        (idle),
        .store_done  (store_done),
        .recall_done (recall_done),
        .cur_src     (cur_src)
    );

    sstore_array #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_array (
        .clk         (clk),
        .rst_n       (rst_n),
        .ce_n        (ce_n),
        .oe_n        (oe_n),
        .we_n        (we_n),
        .hw_req_n    (hw_req_n),
        .addr        (addr),
        .wdata       (wdata),
        .idle        (idle),
        .store_done  (store_done),
        .recall_done (recall_done),
        .rdata       (rdata),
        .rdata_oe    (rdata_oe),
        .dirty       (dirty)
    );

    sstore_counter #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (store_done),
        .cnt   (store_count)
    );

    assign busy_n    = idle;
    assign store_src = cur_src;

    // R4
    gate_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_n |-> !rdata_oe);

    // R8
    clean_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_n && !dirty && !sw_store) |=> busy_n);
endmodule

// File: tb/tb_shadow_store_ctrl.sv
module tb_shadow_store_ctrl;
    localparam int CLK_P      = 10;
    localparam int ADDR_W     = 4;
    localparam int DATA_W     = 8;
    localparam int STORE_CYC  = 8;
    localparam int RECALL_CYC = 6;
    localparam int CNT_W      = 8;
    localparam int CMAX       = (1 << CNT_W) - 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic [ADDR_W-1:0] addr = '0;
    logic [DATA_W-1:0] wdata = '0;
    logic [DATA_W-1:0] rdata;
    logic              rdata_oe;
    logic              hw_req_n = 1'b1;
    logic              sw_store = 1'b0;
    logic              pwr_fail = 1'b0;
    logic              busy_n;
    logic [1:0]        store_src;
    logic [CNT_W-1:0]  store_count;

    int n_tests = 0;
    int n_fail  = 0;
    int exp_cnt = 0;
    bit finished = 0;

    shadow_store_ctrl #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STORE_CYC(STORE_CYC),
        .RECALL_CYC(RECALL_CYC), .CNT_W(CNT_W)
    ) dut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe),
        .hw_req_n(hw_req_n), .sw_store(sw_store), .pwr_fail(pwr_fail),
        .busy_n(busy_n), .store_src(store_src), .store_count(store_count)
    );

    always #(CLK_P/2) clk = ~clk;

    // Vector: {make_dirty, pf, hw, sw, expect_run, expect_src[1:0]}
    localparam int NV = 9;
    localparam logic [6:0] VEC [NV] = '{
        7'b0_100_0_00,   // clean pf: skipped
        7'b0_010_0_00,   // clean hw: skipped
        7'b0_001_1_01,   // clean sw: runs
        7'b1_100_1_11,   // dirty pf
        7'b1_010_1_10,   // dirty hw
        7'b1_111_1_11,   // dirty all: pf wins
        7'b1_011_1_10,   // dirty hw+sw: hw wins
        7'b0_111_1_01,   // clean all: sw still runs
        7'b1_001_1_01    // dirty sw
    };

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic write_word(input int a, input int d);
        @(negedge clk);
        ce_n = 0; we_n = 0; addr = ADDR_W'(a); wdata = DATA_W'(d);
        @(negedge clk);
        ce_n = 1; we_n = 1;
        @(negedge clk);
    endtask

    task automatic read_word(input int a, output int d, output int oe);
        @(negedge clk);
        ce_n = 0; oe_n = 0; we_n = 1; addr = ADDR_W'(a);
        #1;
        d = int'(rdata); oe = int'(rdata_oe);
        ce_n = 1; oe_n = 1;
    endtask

    task automatic trigger(input bit pf, input bit hw, input bit sw,
                           output int bsy, output int src);
        @(negedge clk);
        pwr_fail = pf; hw_req_n = !hw; sw_store = sw;
        @(negedge clk);
        bsy = int'(busy_n); src = int'(store_src);
        pwr_fail = 0; hw_req_n = 1; sw_store = 0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 100 && !busy_n; i++) @(negedge clk);
    endtask

    initial begin : watchdog
        #(CLK_P * 200000);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : main
        int d, oe, bsy, src, n;
        // R5: reset state
        repeat (3) @(negedge clk);
        check("R5 busy in reset", int'(busy_n), 0);
        check("R5 count in reset", int'(store_count), 0);
        rst_n = 1;
        n = 0;
        while (!busy_n && n < 100) begin n++; @(negedge clk); end
        check("R5 recall length", n, RECALL_CYC);

        // R1 R2: write and read back
        write_word(2, 8'h3C);
        write_word(7, 8'hC3);
        read_word(2, d, oe);
        check("R1 oe", oe, 1); check("R2 data a2", d, 8'h3C);
        read_word(7, d, oe);
        check("R2 data a7", d, 8'hC3);

        // R3: oe low during write keeps drivers off; write still lands
        @(negedge clk);
        ce_n = 0; oe_n = 0; we_n = 0; addr = 4'd9; wdata = 8'h5A;
        #1 check("R3 oe off while writing", int'(rdata_oe), 0);
        @(negedge clk);
        ce_n = 1; oe_n = 1; we_n = 1;
        @(negedge clk);
        read_word(9, d, oe);
        check("R2 data a9", d, 8'h5A);

        // R1: negative read conditions
        @(negedge clk);
        ce_n = 1; oe_n = 0; addr = 4'd2;
        #1 check("R1 ce high", int'(rdata_oe), 0);
        ce_n = 0; hw_req_n = 0;
        #1 check("R1 req line low", int'(rdata_oe), 0);
        check("R1 rdata zero", int'(rdata), 0);
        hw_req_n = 1; ce_n = 1; oe_n = 1;

        // clear dirty with a store before the table
        trigger(0, 0, 1, bsy, src); wait_idle(); exp_cnt++;

        // R8 R10 R7 R12: arbitration table
        for (int v = 0; v < NV; v++) begin
            if (VEC[v][6]) write_word(v, 8'h40 + v);
            trigger(VEC[v][5], VEC[v][4], VEC[v][3], bsy, src);
            check($sformatf("R8 busy vec%0d", v), bsy, VEC[v][2] ? 0 : 1);
            check($sformatf("R10 src vec%0d", v), src, int'(VEC[v][1:0]));
            wait_idle();
            if (VEC[v][2]) exp_cnt++;
            check($sformatf("R12 count vec%0d", v), int'(store_count), exp_cnt);
        end

        // R6: store length
        write_word(1, 8'h77);
        @(negedge clk); sw_store = 1;
        @(negedge clk); sw_store = 0;
        n = 0;
        while (!busy_n && n < 100) begin n++; @(negedge clk); end
        exp_cnt++;
        check("R6 store length", n, STORE_CYC);

        // R4 R11: access and triggers during a store
        write_word(3, 8'hA5);
        trigger(0, 0, 1, bsy, src);
        read_word(3, d, oe);
        check("R4 read blocked", oe, 0);
        write_word(3, 8'hEE);
        @(negedge clk); pwr_fail = 1;
        @(negedge clk); pwr_fail = 0;
        wait_idle();
        exp_cnt++;
        @(negedge clk);
        check("R11 dropped pf", int'(busy_n), 1);
        check("R11 count once", int'(store_count), exp_cnt);
        read_word(3, d, oe);
        check("R4 write blocked", d, 8'hA5);

        // R9: dirty cleared by store, so hw is skipped
        trigger(0, 1, 0, bsy, src);
        check("R9 clean after store", bsy, 1);

        // R5: contents survive reset via recall
        write_word(3, 8'h11);
        @(negedge clk); rst_n = 0;
        repeat (2) @(negedge clk); rst_n = 1;
        wait_idle();
        exp_cnt = 0;
        read_word(3, d, oe);
        check("R5 recalled word", d, 8'hA5);
        check("R5 count after reset", int'(store_count), 0);

        // R12: saturation
        for (int k = 0; k < CMAX + 3; k++) begin
            trigger(0, 0, 1, bsy, src); wait_idle();
        end
        check("R12 saturate", int'(store_count), CMAX);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule